// File: doc/BRIEF.md
# Programmable Up-Counting Interval Timer

This block measures repeating time intervals in units of an external tick, normally one per microsecond. Software places a negative count in the next-interval register and then sets the run bit. On that start the live count register is loaded with the next-interval value. Every tick then adds one to the live count. The interval is over when the count would reach zero. At that point the pending flag in the status register is set and the live count is reloaded from the next-interval register, so the timer runs on without software help.

Software reaches three word registers over a simple single-cycle register bus. Address 0 holds status and control. Address 1 holds the next-interval value, which software can read and write. Address 2 holds the live count and is read-only. The interrupt line is the pending flag gated by an enable bit. While the timer runs, a read of the live count shows the elapsed progress. While it is stopped, the count stays frozen at the value it had when the run bit was cleared.

Top module: `icr_timer`

## Requirements
- R1: After reset, all three registers read as zero and `irq` is low.
- R2: Writing the status register with run (bit 0) set, while run was clear, loads the live count from the next-interval register. Before any tick, a read of address 2 returns that value.
- R3: While run is set, each cycle with `tick_en` high increments the live count by one. While run is clear, `tick_en` has no effect on the count.
- R4: The interval length in ticks is the two's complement of the loaded next-interval value. On the last tick of an interval, the pending flag (status bit 2) is set and the live count reloads from the next-interval register.
- R5: A next-interval value of zero gives the maximum interval of 2^W−1 ticks. Counting starts from zero and no interrupt occurs early.
- R6: A read while running returns the next-interval value plus the ticks elapsed. The elapsed part never exceeds the interval length minus one. With next-interval = all ones (length 1), every tick ends an interval and the count stays at all ones.
- R7: Clearing run freezes the live count. Later reads of address 2 return the frozen value regardless of ticks.
- R8: Writing the status register with bit 2 set clears the pending flag. Writing bit 2 as zero leaves the flag unchanged. An interval end in the same cycle as a clear wins.
- R9: `irq` is high exactly when pending and interrupt-enable (status bit 1) are both set.
- R10: A write to the next-interval register while running does not change the current interval. It takes effect at the next reload.
- R11: A read request (`bus_sel` high, `bus_wr` low) gives `bus_rvalid` high with `bus_rdata` one cycle later. The next-interval register reads back what was written, and status reads back {pending, enable, run} in bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address: 0 status, 1 next-interval, 2 live count |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| tick_en | input | 1 | One time unit has elapsed this cycle |
| irq | output | 1 | Interrupt request |

## Verification
A write takes effect at the clock edge that samples it. Read data appears with `bus_rvalid` in the next cycle. A tick sampled at an edge has already changed the count, the pending flag and `irq` just after that edge. The bench drives and samples on falling edges. The driver queues the expected value of each read when it issues the request, and the monitor compares it on the falling edge where `bus_rvalid` is high. Direct checks of `irq` are made on the falling edge that follows the last tick, or the write, that caused them.

// File: rtl/icr_timer_pkg.sv
package icr_timer_pkg;
   // register addresses
   localparam int unsigned ADR_STATUS = 0;
   localparam int unsigned ADR_NEXT   = 1;
   localparam int unsigned ADR_COUNT  = 2;
   // status register bit positions
   localparam int unsigned ST_RUN  = 0;
   localparam int unsigned ST_IE   = 1;
   localparam int unsigned ST_PEND = 2;
   localparam int unsigned ST_BITS = 3;
endpackage

// File: rtl/icr_span_calc.sv
module icr_span_calc #(
   parameter int unsigned WIDTH       = 32,
   parameter bit          ZERO_IS_MAX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] next_val,
   output logic [WIDTH-1:0] span
);
   logic [WIDTH-1:0] negated;

   assign negated = ~next_val + WIDTH'(1);

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         assign span = (next_val == '0) ? '1 : negated;
      end else begin : g_zero_one
         assign span = (negated == '0) ? WIDTH'(1) : negated;
      end
   endgenerate

   // R4
   span_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      span != '0);
endmodule

// File: rtl/icr_count_core.sv
module icr_count_core #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             start,
   input  logic             tick,
   input  logic [WIDTH-1:0] next_val,
   input  logic [WIDTH-1:0] next_span,
   output logic [WIDTH-1:0] count,
   output logic             expire
);
   logic [WIDTH-1:0] count_q;
   logic [WIDTH-1:0] elap_q;
   logic [WIDTH-1:0] span_q;
   logic             last;

   assign last   = (elap_q == span_q - WIDTH'(1));
   assign expire = run && tick && !start && last;
   assign count  = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         elap_q  <= '0;
         span_q  <= WIDTH'(1);
      end else if (start || expire) begin
         count_q <= next_val;
         elap_q  <= '0;
         span_q  <= next_span;
      end else if (run && tick) begin
         count_q <= count_q + WIDTH'(1);
         elap_q  <= elap_q + WIDTH'(1);
      end
   end

   // R6
   elap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (elap_q < span_q));
   // R3
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !start && !last) |=> (count_q == $past(count_q) + WIDTH'(1)));
   // R4
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (count_q == $past(next_val) && elap_q == '0));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(count_q));
endmodule

// File: rtl/icr_reg_file.sv
module icr_reg_file
   import icr_timer_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic [WIDTH-1:0]  count,
   input  logic              expire,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic              bus_rvalid,
   output logic              run,
   output logic              ie,
   output logic              pend,
   output logic              start,
   output logic [WIDTH-1:0]  next_val
);
   logic             run_q, ie_q, pend_q;
   logic [WIDTH-1:0] next_q;
   logic [WIDTH-1:0] rdata_q;
   logic             rvalid_q;
   logic             wr_status, wr_next, rd_req;
   logic [WIDTH-1:0] rd_mux;

   assign wr_status = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_STATUS));
   assign wr_next   = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADR_NEXT));
   assign rd_req    = bus_sel && !bus_wr;
   assign start     = wr_status && bus_wdata[ST_RUN] && !run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
         next_q <= '0;
      end else begin
         if (wr_status) begin
            run_q <= bus_wdata[ST_RUN];
            ie_q  <= bus_wdata[ST_IE];
         end
         if (wr_next) next_q <= bus_wdata;
         if (expire) pend_q <= 1'b1;
         else if (wr_status && bus_wdata[ST_PEND]) pend_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(ADR_STATUS)) begin
         rd_mux[ST_RUN]  = run_q;
         rd_mux[ST_IE]   = ie_q;
         rd_mux[ST_PEND] = pend_q;
      end else if (bus_addr == ADDR_W'(ADR_NEXT)) begin
         rd_mux = next_q;
      end else if (bus_addr == ADDR_W'(ADR_COUNT)) begin
         rd_mux = count;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_req;
         if (rd_req) rdata_q <= rd_mux;
      end
   end

   assign bus_rdata  = rdata_q;
   assign bus_rvalid = rvalid_q;
   assign run        = run_q;
   assign ie         = ie_q;
   assign pend       = pend_q;
   assign next_val   = next_q;

   // R8
   pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(expire));
   // R8
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(wr_status && bus_wdata[ST_PEND])) |=> pend_q);
   // R11
   rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> bus_rvalid);
   // R2
   start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> run_q);
endmodule

// File: rtl/icr_timer.sv
module icr_timer
   import icr_timer_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned ADDR_W      = 2,
   parameter bit          ZERO_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic              bus_rvalid,
   input  logic              tick_en,
   output logic              irq
);
   generate
      if (WIDTH < 8 || WIDTH > 64) begin : g_bad_width
         $error("icr_timer: WIDTH must lie in 8..64");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("icr_timer: ADDR_W must be at least 2");
      end
   endgenerate

   logic             run, ie, pend, start, expire;
   logic [WIDTH-1:0] next_val, next_span, count;

   icr_reg_file #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .count(count), .expire(expire),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .run(run), .ie(ie), .pend(pend), .start(start), .next_val(next_val)
   );

   icr_span_calc #(.WIDTH(WIDTH), .ZERO_IS_MAX(ZERO_IS_MAX)) u_span (
      .clk(clk), .rst_n(rst_n), .next_val(next_val), .span(next_span)
   );

   icr_count_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .start(start), .tick(tick_en),
      .next_val(next_val), .next_span(next_span),
      .count(count), .expire(expire)
   );

   assign irq = pend && ie;

   // R4
   expire_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> pend);
   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ie && !(bus_sel && bus_wr)) |=> irq);
endmodule

// File: tb/icr_timer_bench.sv
`timescale 1ns/1ps
module icr_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        tick_en = 1'b0;
   logic        irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   icr_timer u_icr_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .tick_en(tick_en), .irq(irq)
   );

   // monitor: compare read data against the scoreboard
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         tests++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected read data actual=%h expected=none", bus_rdata);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               fails++;
               $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      tests++;
      if (irq !== e) begin
         fails++;
         $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_irq(1'b0, "R1");
      rd(2'd0, 32'h0, "R1 status");
      rd(2'd1, 32'h0, "R1 next");
      rd(2'd2, 32'h0, "R1 count");
      // R11 readback, R3 ticks ignored while stopped
      wr(2'd1, 32'hFFFF_FFFB);
      rd(2'd1, 32'hFFFF_FFFB, "R11 next readback");
      ticks(3);
      rd(2'd2, 32'h0, "R3 stopped ticks ignored");
      // R2 start loads
      wr(2'd0, 32'h3);
      rd(2'd2, 32'hFFFF_FFFB, "R2 load on start");
      rd(2'd0, 32'h3, "R11 status run+ie");
      // R3 / R6 live count
      ticks(2);
      rd(2'd2, 32'hFFFF_FFFD, "R6 live count");
      // R4 interval end after 5 ticks total
      ticks(2);
      rd(2'd0, 32'h3, "R4 no early end");
      ticks(1);
      chk_irq(1'b1, "R9 irq on end");
      rd(2'd2, 32'hFFFF_FFFB, "R4 reload");
      rd(2'd0, 32'h7, "R4 pending set");
      // R8 clear semantics
      wr(2'd0, 32'h3);
      rd(2'd0, 32'h7, "R8 zero write keeps pending");
      wr(2'd0, 32'h7);
      rd(2'd0, 32'h3, "R8 write one clears");
      chk_irq(1'b0, "R9 irq after clear");
      // R10 next-interval change mid-interval
      wr(2'd1, 32'hFFFF_FFFE);
      ticks(4);
      rd(2'd2, 32'hFFFF_FFFF, "R10 old interval continues");
      ticks(1);
      rd(2'd2, 32'hFFFF_FFFE, "R10 new value at reload");
      chk_irq(1'b1, "R9 irq second end");
      // R9 enable off masks irq
      wr(2'd0, 32'h5);
      rd(2'd0, 32'h1, "R9 ie off, pending cleared");
      ticks(2);
      chk_irq(1'b0, "R9 masked");
      rd(2'd0, 32'h5, "R4 length two");
      // R7 freeze on stop
      ticks(1);
      wr(2'd0, 32'h0);
      ticks(4);
      rd(2'd2, 32'hFFFF_FFFF, "R7 frozen count");
      rd(2'd0, 32'h4, "R7 stopped, pending kept");
      // R6 length one
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, 32'h5);
      ticks(3);
      rd(2'd2, 32'hFFFF_FFFF, "R6 length one never wraps");
      rd(2'd0, 32'h5, "R6 length one pends");
      // R5 zero gives maximum interval
      wr(2'd0, 32'h4);
      rd(2'd0, 32'h0, "R5 stopped and cleared");
      wr(2'd1, 32'h0);
      wr(2'd0, 32'h1);
      rd(2'd2, 32'h0, "R5 load zero");
      ticks(100);
      rd(2'd2, 32'h64, "R5 counts from zero");
      rd(2'd0, 32'h1, "R5 no early end");
      @(negedge clk);
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R11 missing reads actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule